// File: doc/BRIEF.md
# Noise-Tolerant UART with Receiver Standby

This block is a full-duplex asynchronous serial port. Each frame on the wire is NRZ: a low start bit, eight data bits sent least significant bit first, and a high stop bit. All timing comes from a sample tick input `tick16`, which pulses for one clock at sixteen times the baud rate. The transmitter takes items from a valid/ready stream. An item is either a data byte, a whole idle character, or a whole break character. Received bytes leave on a second valid/ready stream, together with plain status flags.

The receiver is built to cope with noise and with baud-rate mismatch. Each data bit is decided by majority over three samples taken at the centre of the bit. The start and stop bits are each judged over seven samples. The bit timing is re-aligned on every falling edge inside a frame. A standby mode lets a node skip traffic meant for other nodes. It ends by itself once the line has been quiet for one full character, so the first character of the next message is received.

Back-pressure rules: an item is transferred on a clock where both valid and ready are high. While `tx_valid` is high, `tx_data` and `tx_kind` must stay stable. While `rx_valid` is high and `rx_ready` is low, the received byte is held and is not replaced.

Top module: `nt_uart`

## Requirements
- R1: A data item is sent as one low start bit, the eight data bits least significant bit first, and one high stop bit. Each bit lasts 16 ticks. The line rests high when nothing is being sent.
- R2: `tx_kind` 1 sends a whole character of ten high bit times, and 2 sends ten low bit times. Both 0 and 3 send data. Queued items follow one another with no gap between them.
- R3: `tx_ready` is high exactly when the one-entry transmit holding register is empty. It falls in the cycle after an accepted transfer, and `txd` changes only on clocks where `tick16` is high.
- R4: A correctly framed byte on `rxd` is presented on `rx_data` with `rx_valid`. It stays unchanged until it is accepted with `rx_ready`.
- R5: Each data bit takes the majority of the samples at tick positions 7, 8 and 9 of the bit (position 0 is the tick on which the bit begins). A single flipped sample does not change the received byte.
- R6: The start bit is judged over positions 3 to 9. Four or more high samples cancel the frame with nothing delivered, and a single high sample is tolerated.
- R7: The stop bit is judged over positions 3 to 9. Four or more low samples set `rx_ferr` with the delivered byte, and the byte is still delivered. `rx_ferr` is rewritten with every delivered byte.
- R8: A falling edge during the data bits re-aligns the bit timing. An edge at position 6 or earlier restarts the current bit. An edge at position 10 or later starts the next bit. Frames with bits of 15 or 17 ticks are received correctly.
- R9: If a frame completes while a byte is still waiting, the old byte is kept and `rx_ovr` is set. `rx_ovr` clears when the waiting byte is accepted.
- R10: A one-cycle `standby_req` sets `rx_standby`. While it is set, completed frames are dropped. It clears after 160 consecutive high line samples, and the following frame is delivered.
- R11: After reset, `txd` is high, `tx_ready` is high, and `rx_valid`, `rx_ovr`, `rx_ferr` and `rx_standby` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-clock pulse at 16 times the baud rate |
| tx_valid | input | 1 | Transmit item offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 8 | Transmit data byte |
| tx_kind | input | 2 | 0 data, 1 idle character, 2 break character, 3 data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer accepts the received byte |
| rx_data | output | 8 | Received byte |
| rx_ovr | output | 1 | A frame was lost because a byte was waiting |
| rx_ferr | output | 1 | Stop bit of the delivered byte was judged low |
| standby_req | input | 1 | Pulse to enter receiver standby |
| rx_standby | output | 1 | Receiver is in standby |

## Verification
The bench flips a single sample in the middle of a data bit, and another inside the start bit and the stop bit. A design that voted on fewer samples, or on the wrong positions, would return a corrupted byte, reject a good start, or raise a false framing error. It also sends frames whose bits are one tick too long and one tick too short. Without edge re-alignment these would decode wrongly or show a framing error. Further cases cover a short low pulse that must not start a frame, a second frame that arrives while the consumer stalls (overrun must keep the first byte), frames sent during standby that must never appear, and an idle and a break character placed between data frames on the exact bit grid.

// File: rtl/nt_uart_pkg.sv
package nt_uart_pkg;
  typedef enum logic [1:0] {
    TXK_DATA  = 2'd0,
    TXK_IDLE  = 2'd1,
    TXK_BREAK = 2'd2,
    TXK_ALT   = 2'd3
  } tx_kind_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/nt_uart_tx.sv
module nt_uart_tx
  import nt_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  tx_kind_e      tx_kind,
  output logic          tx_ready,
  output logic          txd
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(FW + 1);

  logic          hold_full;
  logic [FW-1:0] hold_frame;
  logic [FW-1:0] shreg;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic          take, last, load;

  function automatic logic [FW-1:0] build(tx_kind_e k, logic [DW-1:0] d);
    case (k)
      TXK_IDLE:  build = '1;
      TXK_BREAK: build = '0;
      default:   build = {1'b1, d, 1'b0};
    endcase
  endfunction

  assign tx_ready = !hold_full;
  assign take     = tx_valid && tx_ready;
  assign last     = busy && (cnt == CW'(OSR - 1)) && (left == BW'(1));
  assign load     = tick && hold_full && (!busy || last);
  assign txd      = busy ? shreg[0] : 1'b1;

  // holding register: one item waiting while the shifter runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full  <= 1'b0;
      hold_frame <= '1;
    end else if (take) begin
      hold_full  <= 1'b1;
      hold_frame <= build(tx_kind, tx_data);
    end else if (load) begin
      hold_full  <= 1'b0;
    end
  end

  // shifter: LSB first, OSR ticks per bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      left  <= '0;
      shreg <= '1;
    end else if (load) begin
      busy  <= 1'b1;
      cnt   <= '0;
      left  <= BW'(FW);
      shreg <= hold_frame;
    end else if (tick && busy) begin
      if (cnt == CW'(OSR - 1)) begin
        cnt <= '0;
        if (left == BW'(1)) begin
          busy <= 1'b0;
        end else begin
          shreg <= {1'b1, shreg[FW-1:1]};
          left  <= left - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nt_uart_rx.sv
module nt_uart_rx
  import nt_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          stop_ok
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] LAST   = CW'(OSR - 1);
  localparam logic [CW-1:0] DEC    = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] WIDELO = CW'(OSR / 2 - 5);
  localparam logic [CW-1:0] MIDLO  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] EARLY  = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] LATE   = CW'(OSR / 2 + 2);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [2:0]    ones, ones_n;
  logic [DW-1:0] sh;
  logic          prev, fall, in_win;

  always_comb begin
    fall   = prev & ~rxd_s;
    in_win = (st == RX_DATA) ? (cnt >= MIDLO && cnt <= DEC)
                             : (cnt >= WIDELO && cnt <= DEC);
    ones_n = ones + 3'(in_win & rxd_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      ones    <= '0;
      sh      <= '0;
      prev    <= 1'b1;
      done    <= 1'b0;
      data    <= '0;
      stop_ok <= 1'b1;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= rxd_s;
        unique case (st)
          RX_IDLE: begin
            if (fall) begin
              st   <= RX_START;
              cnt  <= CW'(1);
              ones <= '0;
            end
          end
          RX_START: begin
            cnt  <= cnt + 1'b1;
            ones <= ones_n;
            if (cnt == DEC && ones_n >= 3'd4) begin
              st <= RX_IDLE;
            end else if (cnt == LAST) begin
              st   <= RX_DATA;
              cnt  <= '0;
              ones <= '0;
              idx  <= '0;
            end
          end
          RX_DATA: begin
            if (fall && cnt <= EARLY) begin
              cnt  <= CW'(1);
              ones <= '0;
            end else if ((fall && cnt >= LATE) || cnt == LAST) begin
              cnt  <= fall ? CW'(1) : '0;
              ones <= '0;
              if (idx == IW'(DW - 1)) st <= RX_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt  <= cnt + 1'b1;
              ones <= ones_n;
              if (cnt == DEC) sh <= {(ones_n >= 3'd2), sh[DW-1:1]};
            end
          end
          RX_STOP: begin
            cnt  <= cnt + 1'b1;
            ones <= ones_n;
            if (cnt == DEC) begin
              done    <= 1'b1;
              data    <= sh;
              stop_ok <= (ones_n >= 3'd4);
              st      <= RX_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/nt_uart_rxq.sv
module nt_uart_rxq #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          done,
  input  logic [DW-1:0] data,
  input  logic          stop_ok,
  input  logic          standby_req,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_ovr,
  output logic          rx_ferr,
  output logic          rx_standby
);
  localparam int GAP = OSR * (DW + 2);
  localparam int GW  = $clog2(GAP + 1);

  logic [GW-1:0] quiet;

  // standby entry and quiet-line exit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_standby <= 1'b0;
      quiet      <= '0;
    end else if (standby_req) begin
      rx_standby <= 1'b1;
      quiet      <= '0;
    end else if (tick) begin
      if (!rxd_s) begin
        quiet <= '0;
      end else if (quiet != GW'(GAP)) begin
        quiet <= quiet + 1'b1;
        if (quiet == GW'(GAP - 1)) rx_standby <= 1'b0;
      end
    end
  end

  // one-entry output register with overrun and framing flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ovr   <= 1'b0;
      rx_ferr  <= 1'b0;
    end else if (done && !rx_standby) begin
      if (rx_valid && !rx_ready) begin
        rx_ovr <= 1'b1;
      end else begin
        rx_valid <= 1'b1;
        rx_data  <= data;
        rx_ferr  <= !stop_ok;
        rx_ovr   <= 1'b0;
      end
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
      rx_ovr   <= 1'b0;
    end
  end
endmodule

// File: rtl/nt_uart.sv
module nt_uart
  import nt_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic [1:0]    tx_kind,
  output logic          txd,
  input  logic          rxd,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_ovr,
  output logic          rx_ferr,
  input  logic          standby_req,
  output logic          rx_standby
);
  logic [1:0]    sync;
  logic          rxd_s;
  logic          f_done, f_stop_ok;
  logic [DW-1:0] f_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end
  assign rxd_s = sync[1];

  nt_uart_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_kind(tx_kind_e'(tx_kind)),
    .tx_ready(tx_ready), .txd(txd)
  );

  nt_uart_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s),
    .done(f_done), .data(f_data), .stop_ok(f_stop_ok)
  );

  nt_uart_rxq #(.OSR(OSR), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s),
    .done(f_done), .data(f_data), .stop_ok(f_stop_ok),
    .standby_req(standby_req), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ovr(rx_ovr),
    .rx_ferr(rx_ferr), .rx_standby(rx_standby)
  );
endmodule

// File: rtl/nt_uart_chk.sv
module nt_uart_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick16,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          txd,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          rx_ovr,
  input logic          rx_standby
);
  assert_txd_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick16) |-> $stable(txd));

  assert_ready_falls_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_ovr_keeps_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> (rx_valid && $stable(rx_data)));

  assert_standby_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_standby && $past(rx_standby) && !$past(rx_valid)) |-> !rx_valid);
endmodule

bind nt_uart nt_uart_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_ovr(rx_ovr), .rx_standby(rx_standby)
);

// File: tb/tb_nt_uart.sv
module tb_nt_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic [1:0] tx_kind = '0;
  logic       txd;
  logic       rxd = 1'b1;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic       rx_ovr, rx_ferr;
  logic       standby_req = 1'b0;
  logic       rx_standby;

  int tests = 0;
  int fails = 0;
  int rx_seen = 0;
  logic [8:0] exp_rx[$];
  logic       exp_tx[$];

  nt_uart dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_kind(tx_kind), .txd(txd),
    .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_ovr(rx_ovr), .rx_ferr(rx_ferr), .standby_req(standby_req),
    .rx_standby(rx_standby)
  );

  always #2 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk) tick16 = 1'b0;
    @(negedge clk) tick16 = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      do @(posedge clk); while (tick16 !== 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop, input int bt,
                         input int gbit, input int gpos);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    rxd = 1'b1;
    tk(1);
    for (int i = 0; i < 10; i++)
      for (int s = 0; s < bt; s++) begin
        rxd = fr[i] ^ ((i == gbit) && (s == gpos));
        tk(1);
      end
    rxd = 1'b1;
    tk(3);
  endtask

  task automatic tx_push(input logic [1:0] k, input logic [7:0] d);
    logic [9:0] fr;
    fr = (k == 2'd1) ? 10'h3FF : (k == 2'd2) ? 10'h000 : {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++) exp_tx.push_back(fr[i]);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_kind  = k;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R3 tx_ready after accept", tx_ready, 0);
  endtask

  task automatic tx_mon(input int nbits);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    tk(8);
    for (int i = 0; i < nbits; i++) begin
      if (exp_tx.size() == 0) chk(0, "R1 tx bit without expectation", txd, 0);
      else begin
        logic e;
        e = exp_tx.pop_front();
        chk(txd == e, (i < 10 || i >= 30) ? "R1 data frame bit" : "R2 idle/break bit",
            txd, e);
      end
      if (i != nbits - 1) tk(16);
    end
  endtask

  // receive-side scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      rx_seen++;
      if (exp_rx.size() == 0) chk(0, "R4 unexpected rx byte", rx_data, 0);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        chk({rx_ferr, rx_data} == e, "R4/R7 rx byte and flag", {rx_ferr, rx_data}, e);
      end
    end
  end

  initial begin
    #600000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seen0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11 txd idle", txd, 1);
    chk(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    chk({rx_ovr, rx_ferr, rx_standby} == 3'b000, "R11 flags",
        {rx_ovr, rx_ferr, rx_standby}, 0);

    // R1/R2 transmit: data, idle char, break char, data, back to back
    fork
      tx_mon(40);
      begin
        tx_push(2'd0, 8'hA5);
        tx_push(2'd1, 8'h00);
        tx_push(2'd2, 8'h00);
        tx_push(2'd0, 8'h3C);
      end
    join
    tk(30);
    chk(txd == 1'b1, "R1 line rests high", txd, 1);
    chk(exp_tx.size() == 0, "R2 all tx bits seen", exp_tx.size(), 0);

    // R4 plain byte
    exp_rx.push_back({1'b0, 8'hA5});
    send_rx(8'hA5, 1'b1, 16, -1, 0);
    // R5 single flipped sample in a zero bit and in a one bit
    exp_rx.push_back({1'b0, 8'h3C});
    send_rx(8'h3C, 1'b1, 16, 1, 8);
    exp_rx.push_back({1'b0, 8'h3C});
    send_rx(8'h3C, 1'b1, 16, 3, 8);
    // R6 glitch inside start bit
    exp_rx.push_back({1'b0, 8'h81});
    send_rx(8'h81, 1'b1, 16, 0, 5);
    // R6 false start: short low pulse
    seen0 = rx_seen;
    rxd = 1'b0;
    tk(2);
    rxd = 1'b1;
    tk(40);
    chk(rx_seen == seen0 && rx_valid == 1'b0, "R6 false start ignored", rx_seen - seen0, 0);
    // R7 framing error then recovery, and stop-bit glitch tolerance
    exp_rx.push_back({1'b1, 8'h7E});
    send_rx(8'h7E, 1'b0, 16, -1, 0);
    tk(20);
    exp_rx.push_back({1'b0, 8'h11});
    send_rx(8'h11, 1'b1, 16, -1, 0);
    exp_rx.push_back({1'b0, 8'h00});
    send_rx(8'h00, 1'b1, 16, 9, 5);
    // R8 slow and fast bit times
    exp_rx.push_back({1'b0, 8'h55});
    send_rx(8'h55, 1'b1, 17, -1, 0);
    exp_rx.push_back({1'b0, 8'h55});
    send_rx(8'h55, 1'b1, 15, -1, 0);
    tk(4);
    chk(exp_rx.size() == 0, "R8 all frames delivered", exp_rx.size(), 0);

    // R9 overrun
    rx_ready = 1'b0;
    send_rx(8'h12, 1'b1, 16, -1, 0);
    send_rx(8'h34, 1'b1, 16, -1, 0);
    chk(rx_valid == 1'b1 && rx_data == 8'h12, "R9 old byte kept", rx_data, 8'h12);
    chk(rx_ovr == 1'b1, "R9 overrun set", rx_ovr, 1);
    exp_rx.push_back({1'b0, 8'h12});
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_ovr == 1'b0 && rx_valid == 1'b0, "R9 overrun cleared on accept", rx_ovr, 0);

    // R10 standby
    exp_rx.push_back({1'b0, 8'h5A});
    send_rx(8'h5A, 1'b1, 16, -1, 0);
    standby_req = 1'b1;
    @(negedge clk);
    standby_req = 1'b0;
    seen0 = rx_seen;
    send_rx(8'h0F, 1'b1, 16, -1, 0);
    tk(16);
    send_rx(8'h80, 1'b1, 16, -1, 0);
    chk(rx_standby == 1'b1, "R10 still in standby", rx_standby, 1);
    chk(rx_seen == seen0, "R10 frames dropped", rx_seen - seen0, 0);
    tk(170);
    chk(rx_standby == 1'b0, "R10 wake after quiet line", rx_standby, 0);
    exp_rx.push_back({1'b0, 8'hC3});
    send_rx(8'hC3, 1'b1, 16, -1, 0);
    tk(4);
    chk(exp_rx.size() == 0, "R10 first byte after wake", exp_rx.size(), 0);
    summary();
  end
endmodule